// File: doc/BRIEF.md
# External Memory Bus Cycle Generator

This block turns single requests from a processor core into read and write cycles on an external memory bus with an address bus, active-low read and write strobes and a free-running bus clock. Its clock is a timing tick at twice the oscillator rate, so one tick is half an oscillator period. This lets every strobe edge fall on a half-period boundary. The bus clock runs at one quarter of the oscillator rate, which is eight ticks per period. Each bus cycle lines up with one bus clock period.

The core raises `req` together with the direction (`we`), the address and the write data. It holds them until `ack` pulses. A cycle starts only at a bus clock boundary, so the core may wait up to eight ticks before the cycle begins. The address appears first, then one strobe goes low. For a read, the input bus is sampled at the edge where the strobe rises. For a write, the output data is driven with an enable for the whole cycle. A slow device pulls `wait_n` low to stretch the strobe's low phase, eight ticks at a time.

Top module: `bus_cycle_gen`

## Requirements
- R1: After reset, `rd_n` and `wr_n` are high and `ack` and `bus_doe` are low.
- R2: `bus_clk` runs freely with a period of 8 ticks, high for 4 and low for 4. A cycle's address appears in the first tick of a `bus_clk` high phase, and the strobe falls while `bus_clk` is high.
- R3: With no wait, the address is valid 2 ticks before the strobe falls. The strobe stays low for 5 ticks, and the address is still unchanged in the tick after the strobe rises.
- R4: For a read, `bus_din` is captured at the clock edge where `rd_n` rises. It is shown on `rdata_o` while `ack` is high, and values present at other edges have no effect.
- R5: For a write, `bus_doe` is high and `bus_dout` equals the write data from the tick the address appears, through the tick after `wr_n` rises. `bus_doe` stays low for reads.
- R6: `wait_n` is sampled only at the edge that ends the 4th low tick of the strobe, and again every 8 ticks after that while it was sampled low. Each low sample adds 8 ticks to the strobe's low time, with the address stable. Low `wait_n` at any other tick adds nothing.
- R7: `rd_n` and `wr_n` are never low together, and only the strobe that matches the direction goes low.
- R8: `ack` is a one-tick pulse in the tick after the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing tick, twice the oscillator rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Core request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Request address |
| wdata_i | input | DW | Request write data |
| ack | output | 1 | One-tick completion pulse |
| rdata_o | output | DW | Captured read data |
| bus_addr | output | AW | External address bus |
| bus_dout | output | DW | External write data |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | DW | External read data |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| wait_n | input | 1 | Active-low cycle stretch |
| bus_clk | output | 1 | Bus clock, quarter oscillator rate |

## Verification
A phase counter off by one shows within a single cycle as a strobe falling too early or too late relative to the address, or as a low time other than 5 ticks. A stuck stretch flag shows as a strobe held low in multiples of 8 ticks and a late `ack`. A wrong capture point shows as `rdata_o` holding the deliberately wrong value that the bench drives on every edge except the rising one. Each of these appears at the ports within the first cycle that exercises the state in question.

// File: rtl/bus_cycle_gen.sv
module bus_cycle_gen #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  output logic          rd_n,
  output logic          wr_n,
  input  logic          wait_n,
  output logic          bus_clk
);
  localparam logic [2:0] PH_LAST = 3'd7;
  localparam logic [2:0] PH_FALL = 3'd2;
  localparam logic [2:0] PH_RISE = 3'd7;
  localparam logic [2:0] PH_SMP  = 3'd5;

  logic [2:0] ph, ph_nx;
  logic busy, busy_nx, ext, ext_nx, is_wr, is_wr_nx, low_nx, start;

  assign ph_nx    = ph + 3'd1;
  assign start    = !busy && req && (ph == PH_LAST);
  assign is_wr_nx = start ? we : is_wr;

  always_comb begin
    busy_nx = busy;
    if (start) busy_nx = 1'b1;
    else if (busy && ph == PH_LAST && !ext) busy_nx = 1'b0;
    ext_nx = ext;
    if (busy && ph == PH_SMP) ext_nx = !wait_n;
  end

  assign low_nx  = busy_nx && (ext_nx || (ph_nx >= PH_FALL && ph_nx < PH_RISE));
  assign bus_clk = ~ph[2];
  assign bus_doe = busy && is_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= '0;
      busy     <= 1'b0;
      ext      <= 1'b0;
      is_wr    <= 1'b0;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      ack      <= 1'b0;
      rdata_o  <= '0;
      bus_addr <= '0;
      bus_dout <= '0;
    end else begin
      ph    <= ph_nx;
      busy  <= busy_nx;
      ext   <= ext_nx;
      is_wr <= is_wr_nx;
      rd_n  <= !(low_nx && !is_wr_nx);
      wr_n  <= !(low_nx && is_wr_nx);
      ack   <= busy && ph == PH_LAST && !ext;
      if (start) begin
        bus_addr <= addr_i;
        bus_dout <= wdata_i;
      end
      if (!rd_n && !(low_nx && !is_wr_nx)) rdata_o <= bus_din;
    end
  end

  // R7
  strb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> $stable(bus_addr));
  // R8
  ack_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) || $rose(wr_n)) |=> ack);
  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);
  // R2
  fall_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n)) |-> bus_clk);
  // R5
  wdata_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> bus_doe);
endmodule

// File: tb/bus_cycle_gen_tb.sv
`timescale 1ns/1ps
module bus_cycle_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0, wait_n = 1'b1;
  logic [15:0] addr_i = '0;
  logic [7:0] wdata_i = '0, bus_din = '0;
  logic ack, bus_doe, rd_n, wr_n, bus_clk;
  logic [7:0] rdata_o, bus_dout;
  logic [15:0] bus_addr;
  int vec = 0, bad = 0;

  always #2 clk = ~clk;

  bus_cycle_gen #(.AW(16), .DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr_i(addr_i), .wdata_i(wdata_i),
    .ack(ack), .rdata_o(rdata_o), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .rd_n(rd_n), .wr_n(wr_n),
    .wait_n(wait_n), .bus_clk(bus_clk));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rd_n && wr_n, "R1 strobes high", {rd_n, wr_n}, 3);
    chk(!ack && !bus_doe, "R1 ack/doe low", {ack, bus_doe}, 0);
  endtask

  task automatic t_busclk;
    int run = 0, runs = 0;
    logic prev;
    @(negedge clk); prev = bus_clk;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      run++;
      if (bus_clk != prev) begin
        if (runs > 0) chk(run == 4, "R2 bus_clk half period", run, 4);
        runs++; run = 0; prev = bus_clk;
      end
    end
  endtask

  task automatic run_cycle(input bit w, input logic [15:0] a, input logic [7:0] d,
                           input int nw, input bit stray);
    int a_idx = -1, f_idx = -1, r_idx = -1, k_idx = -1, lowc = 0, exp_low;
    bit excl_ok = 1, addr_ok = 1, doe_ok = 1, bclk_a = 0, bclk_f = 0;
    logic strobe, other;
    logic [7:0] got = '0;
    exp_low = 5 + 8 * nw;
    @(negedge clk);
    req = 1'b1; we = w; addr_i = a; wdata_i = d; bus_din = ~d;
    for (int t = 0; t < 300 && k_idx < 0; t++) begin
      @(negedge clk);
      strobe = w ? wr_n : rd_n;
      other  = w ? rd_n : wr_n;
      if (!other) excl_ok = 0;
      if (a_idx < 0 && bus_addr == a) begin a_idx = t; bclk_a = bus_clk; end
      if (!strobe) begin
        if (f_idx < 0) begin f_idx = t; bclk_f = bus_clk; end
        lowc++;
        if (bus_addr != a) addr_ok = 0;
      end else if (f_idx >= 0 && r_idx < 0) begin
        r_idx = t;
        if (bus_addr != a) addr_ok = 0;
      end
      if (w) begin
        if (a_idx >= 0 && (r_idx < 0 || t == r_idx) && !(bus_doe && bus_dout == d)) doe_ok = 0;
        if (r_idx >= 0 && t > r_idx && bus_doe) doe_ok = 0;
      end else if (bus_doe) doe_ok = 0;
      if (ack) begin k_idx = t; got = rdata_o; req = 1'b0; end
      bus_din = (!strobe && lowc == exp_low) ? d : ~d;
      wait_n = !(!strobe && ((lowc >= 4 && (lowc - 4) % 8 == 0 && (lowc - 4) / 8 < nw)
                              || (stray && (lowc == 2 || lowc == 5))));
    end
    wait_n = 1'b1;
    chk(f_idx - a_idx == 2, "R3 address lead", f_idx - a_idx, 2);
    chk(lowc == exp_low, nw > 0 ? "R6 stretched low time" : "R3 low time", lowc, exp_low);
    chk(addr_ok, "R3/R6 address stable", addr_ok, 1);
    chk(bclk_a && bclk_f, "R2 cycle aligned to bus_clk high", {bclk_a, bclk_f}, 3);
    chk(k_idx == r_idx + 1, "R8 ack after rise", k_idx - r_idx, 1);
    chk(excl_ok, "R7 strobe exclusive", excl_ok, 1);
    chk(doe_ok, "R5 write data window", doe_ok, 1);
    if (!w) chk(got == d, "R4 read capture", got, d);
    @(negedge clk);
    chk(!ack && rd_n && wr_n, "R8 ack one tick, R7 idle high", {ack, rd_n, wr_n}, 3);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_busclk;
    run_cycle(1'b0, 16'h1234, 8'hA5, 0, 1'b0);
    run_cycle(1'b1, 16'h4321, 8'h3C, 0, 1'b0);
    run_cycle(1'b0, 16'hBEEF, 8'h5A, 1, 1'b0);
    run_cycle(1'b1, 16'h0F0F, 8'hC3, 2, 1'b0);
    run_cycle(1'b0, 16'h7001, 8'h96, 0, 1'b1);
    run_cycle(1'b1, 16'h7002, 8'h69, 1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule